// File: doc/BRIEF.md
# Frame-Start Marker with Check-Word Gap Insertion

This block sits on the read side of a symbol FIFO in a modulator output path. While it runs it keeps the FIFO read-enable high. When the symbol being read is flagged as the first of a sync frame, the block raises a frame-start marker on the next cycle.

If gap insertion is enabled and the check-word count sampled at that frame start is N > 0, the block stops reading for N cycles so that Reed-Solomon check words can be placed in the stream. The marker stays high across that gap and for one more cycle. The marker is therefore always N+1 cycles long, and one cycle long when no gap is inserted.

A sequence reset is requested by a falling edge on a sequence-start input. The edge is accepted only if the data-valid input was seen high while sequence-start was high, and is seen high again after the falling edge while sequence-start is low. After an accepted edge, a first-of-sequence flag pulses together with the first cycle of the next frame-start marker.

Top module: `frame_mark_gap`

## Requirements
- R1: While `rst` is high, `rd_en`, `fstart` and `first_seq` are 0. On the first clock edge with `rst` low, `rd_en` goes to 1 and `fstart` stays 0.
- R2: When `frame_bnd` is 1 in a cycle where `rd_en` is 1 and no marker is in progress, `fstart` is 1 in the following cycle.
- R3: When `gap_en` is 0, or `chk_cnt` is 0, at a frame start, `fstart` is high for exactly one cycle and `rd_en` stays 1.
- R4: When `gap_en` is 1 and `chk_cnt` is N > 0 at a frame start, `fstart` is high for exactly N+1 consecutive cycles. `rd_en` is 0 for exactly the first N of those cycles and is 1 in the last one.
- R5: `chk_cnt` and `gap_en` are sampled only in the frame-start cycle. Changing them while a gap is in progress does not change its length.
- R6: `frame_bnd` is ignored in cycles where `rd_en` is 0. It starts no new marker and does not extend the current one.
- R7: After an accepted falling edge of `seq_start`, `first_seq` is a one-cycle pulse in the first cycle of the next `fstart` marker. Later markers do not carry it, until another edge is accepted.
- R8: A falling edge of `seq_start` is not accepted if `din_valid` was not high during the preceding high phase of `seq_start`.
- R9: A falling edge is not accepted until `din_valid` is seen high while `seq_start` is low. Without that, `first_seq` stays 0.
- R10: After a hard reset, `first_seq` stays 0 until a sequence reset is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_bnd | input | 1 | Symbol read this cycle is the first of a sync frame |
| gap_en | input | 1 | Insert a check-word gap at frame start |
| chk_cnt | input | CNT_W | Number of check words in the gap |
| seq_start | input | 1 | Sequence-start level; its falling edge requests a sequence reset |
| din_valid | input | 1 | Input data-valid qualifier |
| rd_en | output | 1 | FIFO read enable; 0 while a gap is inserted |
| fstart | output | 1 | Frame-start marker, N+1 cycles long |
| first_seq | output | 1 | Head-of-sequence pulse on the first marker after a sequence reset |

## Verification
The properties assume that `frame_bnd` is meaningful only while a symbol is actually read. They also assume that `seq_start` and `din_valid` change slowly compared with the synchronizer depth, so that a qualifying edge is resolved well before the next frame start.

The stimulus follows these rules. It holds `frame_bnd` high throughout gaps, which exercises the rule that it is ignored there. It places every sequence-reset pattern inside idle stretches that are at least a dozen cycles long. It never lets an edge acceptance coincide with a frame start.

// File: rtl/fmg_pkg.sv
package fmg_pkg;
  // sequence-reset qualifier states
  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,  // no valid seen while high
    QS_ARMED = 2'd1,  // valid seen while high, waiting for fall
    QS_WAIT  = 2'd2   // fall seen, waiting for valid while low
  } qual_st_e;
endpackage

// File: rtl/fmg_seq_qual.sv
module fmg_seq_qual #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_start,
  input  logic din_valid,
  output logic seq_clr
);
  import fmg_pkg::*;

  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0]          seq_sh;
  logic [SYNC_STAGES-1:0] dv_sh;
  qual_st_e               st_q;
  logic                   seq_lvl, seq_fall, dv_lvl;

  // synchronizer chains plus one edge register on the sequence input
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_sh <= '0;
      dv_sh  <= '0;
    end else begin
      seq_sh <= {seq_sh[SW-2:0], seq_start};
      dv_sh  <= {dv_sh[SYNC_STAGES-2:0], din_valid};
    end
  end

  assign seq_lvl  = seq_sh[SYNC_STAGES-1];
  assign seq_fall = seq_sh[SW-1] & ~seq_lvl;
  assign dv_lvl   = dv_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= QS_IDLE;
      seq_clr <= 1'b0;
    end else begin
      seq_clr <= 1'b0;
      unique case (st_q)
        QS_IDLE: begin
          if (seq_lvl && dv_lvl) st_q <= QS_ARMED;
        end
        QS_ARMED: begin
          if (seq_fall) st_q <= QS_WAIT;
        end
        QS_WAIT: begin
          if (seq_lvl) begin
            st_q <= dv_lvl ? QS_ARMED : QS_IDLE;
          end else if (dv_lvl) begin
            st_q    <= QS_IDLE;
            seq_clr <= 1'b1;
          end
        end
        default: st_q <= QS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fmg_gap_ctrl.sv
module fmg_gap_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_bnd,
  input  logic             gap_en,
  input  logic [CNT_W-1:0] chk_cnt,
  output logic             rd_en,
  output logic             fstart,
  output logic             frm_go
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] gap_len;
  logic             busy;

  assign busy    = (rem_q != '0);
  assign gap_len = gap_en ? chk_cnt : '0;
  // a frame start is taken only while a symbol is actually read
  assign frm_go  = frame_bnd & rd_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      rd_en  <= 1'b0;
      fstart <= 1'b0;
    end else if (busy) begin
      rem_q  <= rem_q - 1'b1;
      fstart <= 1'b1;
      rd_en  <= (rem_q == CNT_W'(1));
    end else if (frm_go) begin
      rem_q  <= gap_len;
      fstart <= 1'b1;
      rd_en  <= (gap_len == '0);
    end else begin
      fstart <= 1'b0;
      rd_en  <= 1'b1;
    end
  end
endmodule

// File: rtl/fmg_frame_tag.sv
module fmg_frame_tag #(
  parameter int FCNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frm_go,
  input  logic seq_clr,
  output logic first_seq
);
  localparam logic [FCNT_W-1:0] FC_MAX = '1;

  // frame index since the last sequence reset; saturated means "none yet"
  logic [FCNT_W-1:0] fidx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fidx_q    <= FC_MAX;
      first_seq <= 1'b0;
    end else begin
      first_seq <= frm_go && (fidx_q == '0);
      if (seq_clr)
        fidx_q <= '0;
      else if (frm_go && fidx_q != FC_MAX)
        fidx_q <= fidx_q + 1'b1;
    end
  end
endmodule

// File: rtl/frame_mark_gap.sv
module frame_mark_gap #(
  parameter int CNT_W       = 5,
  parameter int FCNT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_bnd,
  input  logic             gap_en,
  input  logic [CNT_W-1:0] chk_cnt,
  input  logic             seq_start,
  input  logic             din_valid,
  output logic             rd_en,
  output logic             fstart,
  output logic             first_seq
);
  logic frm_go;
  logic seq_clr;

  fmg_gap_ctrl #(.CNT_W(CNT_W)) u_gap (
    .clk       (clk),
    .rst       (rst),
    .frame_bnd (frame_bnd),
    .gap_en    (gap_en),
    .chk_cnt   (chk_cnt),
    .rd_en     (rd_en),
    .fstart    (fstart),
    .frm_go    (frm_go)
  );

  fmg_seq_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .seq_start (seq_start),
    .din_valid (din_valid),
    .seq_clr   (seq_clr)
  );

  fmg_frame_tag #(.FCNT_W(FCNT_W)) u_tag (
    .clk       (clk),
    .rst       (rst),
    .frm_go    (frm_go),
    .seq_clr   (seq_clr),
    .first_seq (first_seq)
  );
endmodule

// File: rtl/fmg_chk.sv
module fmg_chk (
  input logic clk,
  input logic rst,
  input logic frame_bnd,
  input logic rd_en,
  input logic fstart,
  input logic first_seq
);
  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R2
  frame_rise_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (frame_bnd && rd_en && !(fstart && !rd_en)) |=> fstart);

  // R4
  gap_covered_chk: assert property (@(posedge clk) disable iff (rst || !live)
    !rd_en |-> fstart);

  // R4
  gap_tail_chk: assert property (@(posedge clk) disable iff (rst || !live)
    !rd_en |=> fstart);

  // R4
  marker_end_chk: assert property (@(posedge clk) disable iff (rst || !live)
    $fell(fstart) |-> $past(rd_en));

  // R7
  first_in_marker_chk: assert property (@(posedge clk) disable iff (rst || !live)
    first_seq |-> fstart);

  // R7
  first_single_chk: assert property (@(posedge clk) disable iff (rst || !live)
    first_seq |=> !first_seq);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!fstart && !first_seq));
endmodule

bind frame_mark_gap fmg_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_bnd (frame_bnd),
  .rd_en     (rd_en),
  .fstart    (fstart),
  .first_seq (first_seq)
);

// File: tb/tb_frame_mark_gap.sv
`timescale 1ns/1ps
module tb_frame_mark_gap;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_bnd = 1'b0, gap_en = 1'b0, seq_start = 1'b0, din_valid = 1'b0;
  logic [CW-1:0] chk_cnt = '0;
  logic          rd_en, fstart, first_seq;

  frame_mark_gap #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .frame_bnd(frame_bnd), .gap_en(gap_en),
    .chk_cnt(chk_cnt), .seq_start(seq_start), .din_valid(din_valid),
    .rd_en(rd_en), .fstart(fstart), .first_seq(first_seq)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    stamp;
    logic  rd, fs, fi;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against items pushed before the last edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (rd_en !== e.rd || fstart !== e.fs || first_seq !== e.fi) begin
        n_bad++;
        $display("FAIL %s: rd_en/fstart/first_seq got %b%b%b expected %b%b%b",
                 e.tag, rd_en, fstart, first_seq, e.rd, e.fs, e.fi);
      end
    end
  end

  task automatic step(input logic fb, ge, input logic [CW-1:0] cnt,
                      input logic sq, dv, input logic e_rd, e_fs, e_fi,
                      input string tag);
    exp_t e;
    @(negedge clk);
    frame_bnd = fb; gap_en = ge; chk_cnt = cnt; seq_start = sq; din_valid = dv;
    e.stamp = cyc; e.rd = e_rd; e.fs = e_fs; e.fi = e_fi; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input logic sq, dv, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, '0, sq, dv, 1, 0, 0, tag);
  endtask

  // frame start, then the gap with frame_bnd held high and the count
  // disturbed (R5, R6), then one idle cycle
  task automatic frame(input logic ge, input logic [CW-1:0] cnt,
                       input logic e_first, input string tag);
    int n;
    n = ge ? int'(cnt) : 0;
    step(1, ge, cnt, 0, 0, n == 0, 1, e_first, tag);
    for (int i = 1; i <= n; i++)
      step(1, ~ge, cnt ^ 5'h0B, 0, 0, i == n, 1, 0, "R5/R6");
    idle(1, 0, 0, tag);
  endtask

  task automatic seq_pulse(input logic dv_hi, dv_lo);
    idle(3, 1, dv_hi, "R7");
    idle(1, 1, 0, "R7");
    idle(4, 0, 0, "R7");
    idle(1, 0, dv_lo, "R7");
    idle(6, 0, 0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_en !== 1'b0 || fstart !== 1'b0 || first_seq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset outputs got %b%b%b expected 000", rd_en, fstart, first_seq);
    end
    rst = 1'b0;
    idle(3, 0, 0, "R1");
    frame(0, '0, 0, "R10");
    idle(2, 0, 0, "R2");
    frame(0, 5'd5, 0, "R3");
    frame(1, 5'd0, 0, "R3");
    frame(1, 5'd16, 0, "R4");
    frame(1, 5'd3, 0, "R4");
    frame(1, 5'd1, 0, "R4");
    seq_pulse(1, 1);
    frame(1, 5'd2, 1, "R7");
    frame(0, '0, 0, "R7");
    seq_pulse(0, 1);
    frame(0, '0, 0, "R8");
    seq_pulse(1, 0);
    frame(1, 5'd4, 0, "R9");
    seq_pulse(1, 1);
    frame(1, 5'd31, 1, "R7");
    frame(1, 5'd2, 0, "R7");
    idle(3, 0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int t;
    t = 0;
    while (!done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule